// File: doc/BRIEF.md
# Early Receive Overrun Detector

This block guards a shared receive buffer RAM while a frame is still being written into it. When the host starts copying a frame out before the receive DMA has finished writing it, the host can read a location the DMA has not yet filled. The detector keeps a copy of the local buffer address of the most recent DMA write. It checks every host-side buffer read against that copy. Host reads arrive on two ports: a cache port and an I/O pipe port.

A read whose address equals the last written address, ignoring the two lowest address bits, counts as an overrun. An overrun sets a sticky failure flag and freezes the offending local buffer address into a capture register, which is exposed as a low byte and a high byte. Software reads the captured address, recopies from that point or earlier, and then clears the flag.

Checking is armed by a frame-start pulse, which also loads the frame's first buffer location as the latched address. Checking stops from the cycle in which the DMA reports that the frame is completely buffered.

The compare control machine has two states. CMP_OFF moves to CMP_ON on `frame_start` (the ARM transition). CMP_ON moves to CMP_OFF on `frame_done` without `frame_start` (the DISARM transition).

The flag machine also has two states. FLG_CLEAR moves to FLG_SET on a hit (the TRIP transition). FLG_SET moves to FLG_CLEAR on `host_clr` without a hit (the RELEASE transition). While in FLG_SET, a hit that arrives together with `host_clr` is the RETRIP transition: the machine stays in FLG_SET and captures again.

Top module: `erx_guard`

## Requirements
- R1: After reset `fail_flag` is 0, both capture bytes are 0x00, and comparison is off.
- R2: Every `dma_wr` cycle loads `dma_addr` into the latched address. A `frame_start` cycle without `dma_wr` loads `frame_base` instead; when both occur in the same cycle, `dma_addr` is loaded.
- R3: When comparison is on, a `cache_rd` whose address bits [15:2] equal those of the latched address sets `fail_flag` in the next cycle.
- R4: A `pipe_rd` is compared in the same way and sets `fail_flag` in the next cycle on a match.
- R5: A read whose address differs from the latched address in any bit of [15:2] never sets the flag; bits [1:0] never affect the result.
- R6: Comparison is off from reset until the cycle after `frame_start`. It is also off from the cycle in which `frame_done` is high (including that cycle's reads) until the cycle after the next `frame_start`.
- R7: On a trip, the latched DMA address (not the read address) is captured. Its bits [7:0] appear on `fail_addr_lo` and bits [15:8] on `fail_addr_hi` in the cycle after the match.
- R8: While `fail_flag` is set and `host_clr` is low, the flag stays set and the capture bytes do not change, even on further matches.
- R9: `host_clr` without a match clears `fail_flag` in the next cycle and leaves the capture bytes unchanged.
- R10: When `host_clr` and a match fall in the same cycle, `fail_flag` stays 1 and the capture takes the current latched address.
- R11: `frame_start` re-arms comparison even after `frame_done`, and has priority over `frame_done` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Start of a new early-receive frame |
| frame_base | input | 16 | First buffer location of the new frame |
| frame_done | input | 1 | DMA has placed the whole frame in memory |
| dma_wr | input | 1 | DMA write strobe into buffer RAM |
| dma_addr | input | 16 | Local address of the DMA write |
| cache_rd | input | 1 | Cache port read strobe |
| cache_addr | input | 16 | Local address of the cache port read |
| pipe_rd | input | 1 | I/O pipe port read strobe |
| pipe_addr | input | 16 | Local address of the I/O pipe read |
| host_clr | input | 1 | Host clears the failure flag |
| fail_flag | output | 1 | Sticky early-receive failure flag |
| fail_addr_lo | output | 8 | Captured local address bits [7:0] |
| fail_addr_hi | output | 8 | Captured local address bits [15:8] |

## Verification
Two functions can fall in the same cycle, and both are provoked on purpose.

The first pair is the host clearing the flag and a new read match. The bench first trips the flag. It then moves the DMA address on and issues `host_clr` together with a cache read of the new word. The result passes only if the flag remains set and the capture holds the new latched address.

The second pair is the frame-done indication and a host read of the last written word. Here the flag must stay clear, because comparison is already off in that cycle.

A behavioural reference model runs alongside the design on every clock, including a random phase that mixes all strobes. This phase also covers `frame_start` together with `dma_wr` and `frame_start` together with `frame_done`.

// File: rtl/erx_pkg.sv
package erx_pkg;

    typedef enum logic {
        CMP_OFF = 1'b0,
        CMP_ON  = 1'b1
    } cmp_state_t;

    typedef enum logic {
        FLG_CLEAR = 1'b0,
        FLG_SET   = 1'b1
    } flg_state_t;

endpackage

// File: rtl/erx_cmp_ctrl.sv
// Compare control: arms and disarms the overrun check and keeps the
// last local address written by the receive DMA.
module erx_cmp_ctrl
    import erx_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [ADDR_W-1:0] frame_base,
    input  logic              frame_done,
    input  logic              dma_wr,
    input  logic [ADDR_W-1:0] dma_addr,
    output logic              cmp_en,
    output logic [ADDR_W-1:0] last_addr
);

    cmp_state_t state_q, state_d;
    logic [ADDR_W-1:0] last_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CMP_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: ARM and DISARM, start has priority over done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMP_OFF: begin
                if (frame_start) begin
                    state_d = CMP_ON;
                end
            end
            CMP_ON: begin
                if (frame_done && !frame_start) begin
                    state_d = CMP_OFF;
                end
            end
            default: state_d = CMP_OFF;
        endcase
    end

    // latched DMA address, a write in the start cycle wins over the base
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (dma_wr) begin
            last_q <= dma_addr;
        end else if (frame_start) begin
            last_q <= frame_base;
        end
    end

    // outputs: comparison stops in the very cycle the frame completes
    always_comb begin
        cmp_en    = 1'b0;
        last_addr = last_q;
        unique case (state_q)
            CMP_OFF: cmp_en = 1'b0;
            CMP_ON:  cmp_en = !frame_done;
            default: cmp_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/erx_addr_match.sv
// Word-granular comparison of every read port against the latched address.
module erx_addr_match #(
    parameter int ADDR_W    = 16,
    parameter int GRAN_BITS = 2,
    parameter int NPORT     = 2
) (
    input  logic                          cmp_en,
    input  logic [NPORT-1:0]              rd_vld,
    input  logic [NPORT-1:0][ADDR_W-1:0]  rd_addr,
    input  logic [ADDR_W-1:0]             last_addr,
    output logic                          hit
);

    localparam logic [ADDR_W-1:0] CMP_MASK = {{(ADDR_W-GRAN_BITS){1'b1}}, {GRAN_BITS{1'b0}}};

    logic [NPORT-1:0] port_hit;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [ADDR_W-1:0] diff;
        assign diff        = (rd_addr[p] ^ last_addr) & CMP_MASK;
        assign port_hit[p] = rd_vld[p] && (diff == '0);
    end

    assign hit = cmp_en && (|port_hit);

endmodule

// File: rtl/erx_fail_capture.sv
// Sticky failure flag with the frozen capture of the failing local address.
module erx_fail_capture
    import erx_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              host_clr,
    input  logic [ADDR_W-1:0] last_addr,
    output logic              fail_flag,
    output logic [ADDR_W-1:0] cap_addr
);

    flg_state_t state_q, state_d;
    logic              load;
    logic [ADDR_W-1:0] cap_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FLG_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and capture strobe: TRIP, RELEASE, RETRIP
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            FLG_CLEAR: begin
                if (hit) begin
                    state_d = FLG_SET;
                    load    = 1'b1;
                end
            end
            FLG_SET: begin
                if (host_clr && hit) begin
                    load    = 1'b1;
                end else if (host_clr) begin
                    state_d = FLG_CLEAR;
                end
            end
            default: state_d = FLG_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (load) begin
            cap_q <= last_addr;
        end
    end

    // outputs
    always_comb begin
        fail_flag = 1'b0;
        cap_addr  = cap_q;
        unique case (state_q)
            FLG_CLEAR: fail_flag = 1'b0;
            FLG_SET:   fail_flag = 1'b1;
            default:   fail_flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/erx_guard.sv
// Early receive overrun detector, top level.
module erx_guard #(
    parameter int REG_W     = 8,
    parameter int ADDR_W    = 2 * REG_W,
    parameter int GRAN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [ADDR_W-1:0] frame_base,
    input  logic              frame_done,
    input  logic              dma_wr,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic              cache_rd,
    input  logic [ADDR_W-1:0] cache_addr,
    input  logic              pipe_rd,
    input  logic [ADDR_W-1:0] pipe_addr,
    input  logic              host_clr,
    output logic              fail_flag,
    output logic [REG_W-1:0]  fail_addr_lo,
    output logic [REG_W-1:0]  fail_addr_hi
);

    localparam int NPORT = 2;

    logic                         cmp_en;
    logic [ADDR_W-1:0]            last_addr;
    logic                         rd_hit;
    logic [NPORT-1:0]             rd_vld;
    logic [NPORT-1:0][ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0]            cap_addr;

    assign rd_vld  = {pipe_rd, cache_rd};
    assign rd_addr = {pipe_addr, cache_addr};

    erx_cmp_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_base  (frame_base),
        .frame_done  (frame_done),
        .dma_wr      (dma_wr),
        .dma_addr    (dma_addr),
        .cmp_en      (cmp_en),
        .last_addr   (last_addr)
    );

    erx_addr_match #(
        .ADDR_W    (ADDR_W),
        .GRAN_BITS (GRAN_BITS),
        .NPORT     (NPORT)
    ) u_match (
        .cmp_en    (cmp_en),
        .rd_vld    (rd_vld),
        .rd_addr   (rd_addr),
        .last_addr (last_addr),
        .hit       (rd_hit)
    );

    erx_fail_capture #(
        .ADDR_W (ADDR_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (rd_hit),
        .host_clr  (host_clr),
        .last_addr (last_addr),
        .fail_flag (fail_flag),
        .cap_addr  (cap_addr)
    );

    assign fail_addr_lo = cap_addr[REG_W-1:0];
    assign fail_addr_hi = cap_addr[ADDR_W-1:REG_W];

endmodule

// File: rtl/erx_guard_chk.sv
// Property checker attached to the top level.
module erx_guard_chk #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             frame_done,
    input logic             host_clr,
    input logic             rd_hit,
    input logic             fail_flag,
    input logic [REG_W-1:0] fail_addr_lo,
    input logic [REG_W-1:0] fail_addr_hi
);

    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> fail_flag); // R3

    AST_FLAG_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_flag) |-> $past(rd_hit)); // R3

    AST_DONE_STOPS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_start) |=> !rd_hit); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_flag && !host_clr) |=> fail_flag); // R8

    AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_flag && !host_clr) |=> $stable({fail_addr_hi, fail_addr_lo})); // R8

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_clr && !rd_hit) |=> !fail_flag); // R9

    AST_CLEAR_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_clr && !rd_hit) |=> $stable({fail_addr_hi, fail_addr_lo})); // R9

    AST_CLEAR_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_clr && rd_hit) |=> fail_flag); // R10

endmodule

bind erx_guard erx_guard_chk #(
    .REG_W (REG_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .frame_done   (frame_done),
    .host_clr     (host_clr),
    .rd_hit       (rd_hit),
    .fail_flag    (fail_flag),
    .fail_addr_lo (fail_addr_lo),
    .fail_addr_hi (fail_addr_hi)
);

// File: tb/erx_guard_bench.sv
module erx_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [15:0] frame_base = '0;
    logic        frame_done = 1'b0;
    logic        dma_wr = 1'b0;
    logic [15:0] dma_addr = '0;
    logic        cache_rd = 1'b0;
    logic [15:0] cache_addr = '0;
    logic        pipe_rd = 1'b0;
    logic [15:0] pipe_addr = '0;
    logic        host_clr = 1'b0;
    logic        fail_flag;
    logic [7:0]  fail_addr_lo;
    logic [7:0]  fail_addr_hi;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    string phase = "R1";

    always #2 clk = ~clk;

    erx_guard u_erx_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .frame_base   (frame_base),
        .frame_done   (frame_done),
        .dma_wr       (dma_wr),
        .dma_addr     (dma_addr),
        .cache_rd     (cache_rd),
        .cache_addr   (cache_addr),
        .pipe_rd      (pipe_rd),
        .pipe_addr    (pipe_addr),
        .host_clr     (host_clr),
        .fail_flag    (fail_flag),
        .fail_addr_lo (fail_addr_lo),
        .fail_addr_hi (fail_addr_hi)
    );

    // behavioural reference model
    bit        m_on = 0;
    bit        m_flag = 0;
    int        m_last = 0;
    int        m_cap = 0;

    function automatic bit same_word(input logic [15:0] a, input int b);
        return (int'(a) / 4) == (b / 4);
    endfunction

    always @(posedge clk) begin
        bit match;
        if (!rst_n) begin
            m_on = 0; m_flag = 0; m_last = 0; m_cap = 0;
        end else begin
            match = m_on && !frame_done &&
                    ((cache_rd && same_word(cache_addr, m_last)) ||
                     (pipe_rd && same_word(pipe_addr, m_last)));
            if (match && (!m_flag || host_clr)) begin
                m_flag = 1; m_cap = m_last;
            end else if (host_clr) begin
                m_flag = 0;
            end
            if (frame_start) m_on = 1;
            else if (frame_done) m_on = 0;
            if (dma_wr) m_last = int'(dma_addr);
            else if (frame_start) m_last = int'(frame_base);
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (fail_flag !== m_flag || {fail_addr_hi, fail_addr_lo} !== 16'(m_cap)) begin
                failures++;
                $display("FAIL %s model: flag=%0b addr=%04h expected flag=%0b addr=%04h",
                         phase, fail_flag, {fail_addr_hi, fail_addr_lo}, m_flag, 16'(m_cap));
            end
        end
    end

    task automatic chk(input string tag, input bit ef, input logic [15:0] ea);
        checks++;
        if (fail_flag !== ef || {fail_addr_hi, fail_addr_lo} !== ea) begin
            failures++;
            $display("FAIL %s: flag=%0b addr=%04h expected flag=%0b addr=%04h",
                     tag, fail_flag, {fail_addr_hi, fail_addr_lo}, ef, ea);
        end
    endtask

    task automatic idle();
        frame_start = 0; frame_done = 0; dma_wr = 0;
        cache_rd = 0; pipe_rd = 0; host_clr = 0;
    endtask

    // each helper drives one cycle and returns at the next falling edge
    task automatic wr(input logic [15:0] a);
        dma_wr = 1; dma_addr = a; @(negedge clk); idle();
    endtask
    task automatic crd(input logic [15:0] a);
        cache_rd = 1; cache_addr = a; @(negedge clk); idle();
    endtask
    task automatic prd(input logic [15:0] a);
        pipe_rd = 1; pipe_addr = a; @(negedge clk); idle();
    endtask
    task automatic clr();
        host_clr = 1; @(negedge clk); idle();
    endtask
    task automatic start(input logic [15:0] b);
        frame_start = 1; frame_base = b; @(negedge clk); idle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1", 0, 16'h0000);
        rst_n = 1;
        @(negedge clk);
        chk("R1", 0, 16'h0000);

        phase = "R6";
        crd(16'h0000);
        chk("R6", 0, 16'h0000);

        phase = "R2";
        start(16'h1200);
        wr(16'h1200); wr(16'h1204); wr(16'h1208);

        phase = "R5";
        crd(16'h1204);
        chk("R5", 0, 16'h0000);
        crd(16'h120C);
        chk("R5", 0, 16'h0000);

        phase = "R3";
        crd(16'h120B);
        chk("R3", 1, 16'h1208);
        chk("R7", 1, 16'h1208);

        phase = "R8";
        wr(16'h1210);
        prd(16'h1212);
        chk("R8", 1, 16'h1208);
        @(negedge clk);
        chk("R8", 1, 16'h1208);

        phase = "R9";
        clr();
        chk("R9", 0, 16'h1208);

        phase = "R4";
        prd(16'h1211);
        chk("R4", 1, 16'h1210);
        clr();

        phase = "R10";
        wr(16'h1300);
        prd(16'h1302);
        chk("R10", 1, 16'h1300);
        wr(16'h1304);
        host_clr = 1; cache_rd = 1; cache_addr = 16'h1307;
        @(negedge clk); idle();
        chk("R10", 1, 16'h1304);
        clr();
        chk("R9", 0, 16'h1304);

        phase = "R6";
        frame_done = 1; cache_rd = 1; cache_addr = 16'h1305;
        @(negedge clk); idle();
        chk("R6", 0, 16'h1304);
        crd(16'h1304);
        chk("R6", 0, 16'h1304);

        phase = "R11";
        start(16'h2000);
        crd(16'h2003);
        chk("R11", 1, 16'h2000);
        clr();
        frame_start = 1; frame_base = 16'h3000; dma_wr = 1; dma_addr = 16'h3104;
        @(negedge clk); idle();
        crd(16'h3000);
        chk("R2", 0, 16'h2000);
        crd(16'h3106);
        chk("R2", 1, 16'h3104);
        clr();
        frame_start = 1; frame_base = 16'h4000; frame_done = 1;
        @(negedge clk); idle();
        prd(16'h4001);
        chk("R11", 1, 16'h4000);
        clr();

        phase = "R7";
        for (int i = 0; i < 3000; i++) begin
            int base;
            base = 16'h5000 + ($urandom_range(0, 3) * 4);
            frame_start = ($urandom_range(0, 19) == 0);
            frame_base  = 16'(base);
            frame_done  = ($urandom_range(0, 24) == 0);
            dma_wr      = ($urandom_range(0, 2) == 0);
            dma_addr    = 16'(base + $urandom_range(0, 15));
            cache_rd    = ($urandom_range(0, 2) == 0);
            cache_addr  = 16'(base + $urandom_range(0, 15));
            pipe_rd     = ($urandom_range(0, 3) == 0);
            pipe_addr   = 16'(base + $urandom_range(0, 15));
            host_clr    = ($urandom_range(0, 5) == 0);
            @(negedge clk);
        end
        idle();
        @(negedge clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule